// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Window

This block is the register front end of a two-channel IDE bus-master DMA controller. It occupies a 16-byte I/O window. Bit 3 of the access address picks the channel. Within a channel's 8 bytes, the four lowest offsets are byte registers:

- 0: command
- 1: shared mode byte
- 2: status
- 3: timing

Offsets 4 to 7 hold a 32-bit pointer to the descriptor table. The block decodes each access, applies the write rules of each field and returns read data in the same cycle as the request.

The command byte goes to the transfer engine together with a one-cycle strobe. The status byte mixes three kinds of bits:

- bits 6:5 are plain writable bits;
- bit 0 copies the engine's active flag and cannot be written;
- bits 2:1 are latched event flags that are cleared by writing 1.

The mode byte is shared by both channels and is owned by the interrupt logic. Reads of it come in on a side input. A write forwards only two bits of it, with a strobe, so that the interrupt logic can recompute its output.

Top module: `bm_window`

## Requirements
- R1: After reset, the following read as zero: the command, status, timing and pointer registers of both channels, and both strobe outputs.
- R2: Address bit 3 selects channel 1 (offsets 8–15) or channel 0 (offsets 0–7). An access to one channel never changes the other channel's registers.
- R3: At offsets 0–3, only 1-byte accesses (acc_size_i = 0) are honoured. A 2-byte read (size code 1) returns 0x0000FFFF, and a 4-byte read (size code 2 or 3) returns 0xFFFFFFFF. Writes of those widths change nothing and raise no strobe.
- R4: A byte write at offset 0 stores the command byte, which reads back and appears on cmd_o. On the next clock, cmd_wr_o pulses high for one cycle on the written channel's bit.
- R5: A byte read at offset 1 of either channel returns mode_i. A byte write there pulses mode_wr_o for one cycle on the next clock, with mode_wbits_o equal to bits 5:4 of the written data.
- R6: Status bits 6:5 take the written value. Status bits 7, 4 and 3 always read 0.
- R7: Status bit 0 equals eng_active_i of its channel, delayed by one clock. Writes do not change it.
- R8: Status bit 1 (error) is set by an eng_err_i pulse and bit 2 (interrupt) by an eng_irq_i pulse. Writing 1 to either bit clears it; writing 0 leaves it unchanged. A set event in the same cycle as a clearing write leaves the bit set.
- R9: A byte write at offset 3 stores that channel's timing byte, which reads back unchanged.
- R10: Only a 4-byte access at offset 4 reaches the descriptor pointer. Written bits 1:0 are stored as 0, and the value is shown on dtp_o. Any other access to offsets 4–7 reads as all ones of its width and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 4 | Byte offset in the window |
| acc_size_i | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| acc_wdata_i | input | 32 | Write data, little-endian, low byte first |
| rd_data_o | output | 32 | Read data, valid in the request cycle |
| mode_i | input | 8 | Shared mode byte from the interrupt logic |
| mode_wr_o | output | 1 | Strobe: mode bits written |
| mode_wbits_o | output | 2 | Written mode bits 5:4 |
| cmd_o | output | 16 | Command bytes, channel 1 in the upper byte |
| cmd_wr_o | output | 2 | Per-channel command write strobe |
| dtp_o | output | 64 | Descriptor pointers, channel 1 in the upper word |
| eng_active_i | input | 2 | Per-channel engine active flag |
| eng_err_i | input | 2 | Per-channel error event pulse |
| eng_irq_i | input | 2 | Per-channel interrupt event pulse |

## Verification
On every cycle, the assertions check the following:
- the command and mode strobes follow their byte writes;
- wide accesses raise no strobe;
- status bit 0 tracks the active input;
- a set event beats a clearing write;
- a write of 1 clears an event bit when no event is present.

Only the bench's scenarios can show the rest:
- the read-back values;
- the width masks of all-ones reads;
- the isolation between the two channels;
- the alignment of the pointer.

The bench covers these by comparing complete read data against values predicted from the register rules.

// File: rtl/bm_window.sv
module bm_window #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid_i,
  input  logic            acc_write_i,
  input  logic [AW-1:0]   acc_addr_i,
  input  logic [1:0]      acc_size_i,
  input  logic [DW-1:0]   acc_wdata_i,
  output logic [DW-1:0]   rd_data_o,
  input  logic [7:0]      mode_i,
  output logic            mode_wr_o,
  output logic [1:0]      mode_wbits_o,
  output logic [1:0][7:0] cmd_o,
  output logic [1:0]      cmd_wr_o,
  output logic [1:0][DW-1:0] dtp_o,
  input  logic [1:0]      eng_active_i,
  input  logic [1:0]      eng_err_i,
  input  logic [1:0]      eng_irq_i
);
  localparam logic [2:0] OFF_CMD = 3'd0, OFF_MODE = 3'd1, OFF_STS = 3'd2,
                         OFF_TIM = 3'd3, OFF_PTR = 3'd4;

  logic [1:0][7:0]    sts_q, tim_q;
  logic [1:0][DW-1:0] dtp_q;
  logic [DW-1:0]      ones;

  wire       ch       = acc_addr_i[3];
  wire [2:0] off      = acc_addr_i[2:0];
  wire [1:0] sel      = ch ? 2'b10 : 2'b01;
  wire       byte_acc = (acc_size_i == 2'd0);
  wire       wr       = acc_valid_i & acc_write_i;
  wire       rd       = acc_valid_i & ~acc_write_i;
  wire       reg_wr   = wr & byte_acc & ~off[2];
  wire       ptr_acc  = acc_size_i[1] & (off == OFF_PTR);

  assign ones  = (acc_size_i == 2'd0) ? DW'(32'h0000_00FF) :
                 (acc_size_i == 2'd1) ? DW'(32'h0000_FFFF) : '1;
  assign dtp_o = dtp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_o        <= '0;
      cmd_wr_o     <= '0;
      sts_q        <= '0;
      tim_q        <= '0;
      dtp_q        <= '0;
      mode_wr_o    <= 1'b0;
      mode_wbits_o <= '0;
    end else begin
      cmd_wr_o  <= '0;
      mode_wr_o <= 1'b0;
      if (reg_wr && off == OFF_MODE) begin
        mode_wr_o    <= 1'b1;
        mode_wbits_o <= acc_wdata_i[5:4];
      end
      for (int c = 0; c < 2; c++) begin
        sts_q[c][0]   <= eng_active_i[c];
        sts_q[c][2:1] <= (sts_q[c][2:1] &
                          ~((reg_wr && sel[c] && off == OFF_STS) ? acc_wdata_i[2:1] : 2'b00))
                         | {eng_irq_i[c], eng_err_i[c]};
        if (reg_wr && sel[c] && off == OFF_STS) sts_q[c][6:5] <= acc_wdata_i[6:5];
        if (reg_wr && sel[c] && off == OFF_CMD) begin
          cmd_o[c]    <= acc_wdata_i[7:0];
          cmd_wr_o[c] <= 1'b1;
        end
        if (reg_wr && sel[c] && off == OFF_TIM) tim_q[c] <= acc_wdata_i[7:0];
        if (wr && ptr_acc && sel[c]) dtp_q[c] <= {acc_wdata_i[DW-1:2], 2'b00};
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd) begin
      if (!off[2]) begin
        if (byte_acc) begin
          unique case (off[1:0])
            2'd0:    rd_data_o = DW'(cmd_o[ch]);
            2'd1:    rd_data_o = DW'(mode_i);
            2'd2:    rd_data_o = DW'(sts_q[ch]);
            default: rd_data_o = DW'(tim_q[ch]);
          endcase
        end else begin
          rd_data_o = ones;
        end
      end else if (ptr_acc) begin
        rd_data_o = dtp_q[ch];
      end else begin
        rd_data_o = ones;
      end
    end
  end

  AST_CMD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && off == OFF_CMD) |=> cmd_wr_o[$past(ch)] && $countones(cmd_wr_o) == 1); // R4
  AST_MODE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && off == OFF_MODE) |=> mode_wr_o && mode_wbits_o == $past(acc_wdata_i[5:4])); // R5
  AST_WIDE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !byte_acc && !off[2]) |=> cmd_wr_o == 2'b00 && !mode_wr_o); // R3
  AST_ACTIVE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active_i[0] |=> sts_q[0][0]); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_irq_i[0] |=> sts_q[0][2]); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !ch && off == OFF_STS && acc_wdata_i[1] && !eng_err_i[0]) |=> !sts_q[0][1]); // R8
endmodule

// File: tb/sim_bm_window.sv
module sim_bm_window;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_valid_i = 0, acc_write_i = 0;
  logic [3:0]  acc_addr_i = '0;
  logic [1:0]  acc_size_i = '0;
  logic [31:0] acc_wdata_i = '0;
  logic [31:0] rd_data_o;
  logic [7:0]  mode_i = '0;
  logic        mode_wr_o;
  logic [1:0]  mode_wbits_o;
  logic [1:0][7:0]  cmd_o;
  logic [1:0]  cmd_wr_o;
  logic [1:0][31:0] dtp_o;
  logic [1:0]  eng_active_i = '0, eng_err_i = '0, eng_irq_i = '0;

  int compared = 0, mismatched = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  bm_window u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [1:0] s, logic [31:0] d);
    @(posedge clk); #1;
    acc_valid_i = 1; acc_write_i = 1; acc_addr_i = a; acc_size_i = s; acc_wdata_i = d;
    @(posedge clk); #1;
    acc_valid_i = 0; acc_write_i = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [1:0] s, logic [31:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    acc_valid_i = 1; acc_write_i = 0; acc_addr_i = a; acc_size_i = s;
    @(posedge clk); #1;
    acc_valid_i = 0;
  endtask

  task automatic pulse(logic [1:0] irq, logic [1:0] err);
    @(posedge clk); #1;
    eng_irq_i = irq; eng_err_i = err;
    @(posedge clk); #1;
    eng_irq_i = '0; eng_err_i = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n && acc_valid_i && !acc_write_i) begin
      if (exp_q.size() == 0) chk("monitor: unexpected read", rd_data_o, 32'hx);
      else chk(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    // R1 reset state
    rd(4'd0, 2'd0, 32'h0, "R1 cmd0 reset");
    rd(4'd10, 2'd0, 32'h0, "R1 sts1 reset");
    rd(4'd11, 2'd0, 32'h0, "R1 tim1 reset");
    rd(4'd4, 2'd2, 32'h0, "R1 ptr0 reset");
    chk("R1 strobes reset", {29'd0, mode_wr_o, cmd_wr_o}, 32'h0);
    // R5 shared mode byte
    mode_i = 8'hA5;
    rd(4'd1, 2'd0, 32'hA5, "R5 mode via ch0");
    rd(4'd9, 2'd0, 32'hA5, "R5 mode via ch1");
    wr(4'd9, 2'd0, 32'hFF);
    chk("R5 mode strobe bits", {30'd0, mode_wr_o, mode_wbits_o == 2'b11}, 32'h3);
    wr(4'd1, 2'd0, 32'h10);
    chk("R5 mode bits 01", {31'd0, mode_wr_o} << 2 | mode_wbits_o, 32'h5);
    // R4 command byte, R2 channel isolation
    wr(4'd0, 2'd0, 32'h09);
    chk("R4 cmd0 strobe", cmd_wr_o, 32'h1);
    chk("R4 cmd0 out", cmd_o[0], 32'h09);
    wr(4'd8, 2'd0, 32'h01);
    chk("R4 cmd1 strobe", cmd_wr_o, 32'h2);
    rd(4'd0, 2'd0, 32'h09, "R2 cmd0 untouched by ch1");
    rd(4'd8, 2'd0, 32'h01, "R4 cmd1 readback");
    // R3 wide accesses
    rd(4'd0, 2'd1, 32'h0000FFFF, "R3 2-byte read");
    rd(4'd2, 2'd2, 32'hFFFFFFFF, "R3 4-byte read");
    wr(4'd0, 2'd1, 32'h0);
    chk("R3 wide write no strobe", cmd_wr_o, 32'h0);
    rd(4'd0, 2'd0, 32'h09, "R3 cmd0 kept after wide write");
    // R9 timing
    wr(4'd3, 2'd0, 32'h5A);
    wr(4'd11, 2'd0, 32'hC3);
    rd(4'd3, 2'd0, 32'h5A, "R9 tim0");
    rd(4'd11, 2'd0, 32'hC3, "R9 tim1");
    wr(4'd3, 2'd2, 32'h0);
    rd(4'd3, 2'd0, 32'h5A, "R3 tim0 kept after wide write");
    // R6 writable bits
    wr(4'd2, 2'd0, 32'hFF);
    rd(4'd2, 2'd0, 32'h60, "R6 status after 0xFF");
    wr(4'd2, 2'd0, 32'h00);
    rd(4'd2, 2'd0, 32'h00, "R6 status after 0x00");
    // R7 active mirror
    eng_active_i = 2'b01;
    rd(4'd2, 2'd0, 32'h01, "R7 active bit set");
    wr(4'd2, 2'd0, 32'h01);
    rd(4'd2, 2'd0, 32'h01, "R7 write does not clear active");
    rd(4'd10, 2'd0, 32'h00, "R7 ch1 active clear");
    eng_active_i = 2'b00;
    // R8 events
    pulse(2'b01, 2'b01);
    rd(4'd2, 2'd0, 32'h06, "R8 both events latched");
    wr(4'd2, 2'd0, 32'h00);
    rd(4'd2, 2'd0, 32'h06, "R8 write 0 keeps events");
    wr(4'd2, 2'd0, 32'h02);
    rd(4'd2, 2'd0, 32'h04, "R8 clear error only");
    wr(4'd2, 2'd0, 32'h04);
    rd(4'd2, 2'd0, 32'h00, "R8 clear irq");
    pulse(2'b10, 2'b00);
    rd(4'd10, 2'd0, 32'h04, "R8 ch1 irq latched");
    rd(4'd2, 2'd0, 32'h00, "R2 ch0 status untouched");
    @(posedge clk); #1;
    acc_valid_i = 1; acc_write_i = 1; acc_addr_i = 4'd2; acc_size_i = 0; acc_wdata_i = 32'h04;
    eng_irq_i = 2'b01;
    @(posedge clk); #1;
    acc_valid_i = 0; acc_write_i = 0; eng_irq_i = 0;
    rd(4'd2, 2'd0, 32'h04, "R8 set wins over clear");
    // R10 descriptor pointer
    wr(4'd4, 2'd2, 32'h12345677);
    wr(4'd12, 2'd3, 32'hFFFFFFFF);
    rd(4'd4, 2'd2, 32'h12345674, "R10 ptr0 aligned");
    rd(4'd12, 2'd2, 32'hFFFFFFFC, "R10 ptr1 aligned");
    chk("R10 dtp_o ch0", dtp_o[0], 32'h12345674);
    wr(4'd5, 2'd0, 32'h00);
    wr(4'd4, 2'd1, 32'h00);
    rd(4'd4, 2'd2, 32'h12345674, "R10 narrow writes ignored");
    rd(4'd4, 2'd0, 32'h000000FF, "R10 byte read ones");
    rd(4'd6, 2'd1, 32'h0000FFFF, "R10 halfword read ones");
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) chk("monitor: reads left", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule